// File: doc/BRIEF.md
# Module Clock Stop Controller

This block holds one stop bit for each peripheral module of a chip and turns those bits into per-module clock-enable signals. Modules are grouped 32 to a 32-bit register. Each group has a control word that software can read and write, and a status word that is read-only. A control bit at 1 holds that module's clock stopped. A control bit at 0 lets the clock run. The enable outputs are ordinary registered logic levels that drive the gating cells elsewhere in the chip.

The status word tells software when a requested change has really taken effect. After software clears a stop bit, it polls the matching status bit until the bit reads 0, and only then treats the module as running. Software gives up after roughly a thousand polls, so `SETTLE` must be at least 1 and well under that figure. Setting a stop bit needs no confirmation, because the enable drops on the next cycle. The status bit still follows the control bit after the same delay in both directions. If a control bit changes again before its delay has run out, the delay for that bit starts over.

Access is through a word-addressed register port with separate write and read strobes. Write data is taken in the cycle the write strobe is high. Read data appears one cycle after the read strobe.

Top module: `ckstop_ctrl`

## Requirements
- R1: After reset every control bit and every status bit reads 1, every bit of `mod_clk_en` is 0, and `bus_rdata` is 0.
- R2: Module n belongs to control word n/32, at bit n%32. Control word w sits at word address `CTRL_BASE`+w (default 0x040, with `NUM_WORDS`=4). A full-word write there is stored and reads back unchanged.
- R3: `mod_clk_en[n]` is the inverse of module n's control bit. It changes on the first clock edge after the edge that stored the write: 1 means the clock runs, 0 means it is stopped.
- R4: When a control bit goes from 1 to 0 (start), its status bit, read at `STAT_BASE`+w (default 0x080), changes to 0 exactly `SETTLE` clock edges after the edge that stored the write.
- R5: When a control bit goes from 0 to 1 (stop), the enable drops one edge later with no wait. The status bit still reads 0 until exactly `SETTLE` edges after the write, and then reads 1.
- R6: If a control bit changes again before its status has followed, the delay restarts from the latest change. If the bit returns to the value its status already shows, the status never changes.
- R7: Writes to status addresses change no control bit, no status bit and no enable.
- R8: Writes to any address that is neither a control word nor a status word are ignored, and reads from such an address return 0.
- R9: `bus_rdata` carries the addressed word on the cycle after `bus_rd` is high, and it is 0 on every cycle after one in which `bus_rd` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| mod_clk_en | output | NUM_WORDS*32 | Per-module clock enable, 1 = running |

## Verification
The hardest case to reach from the ports is a control bit that changes again while its settle delay is still running. A faulty design that keeps counting from the first change looks the same as a correct one unless the status is caught on the exact edge where the two differ. To catch it, the bench spaces its toggles more closely than `SETTLE`. After the last write it issues reads on every cycle, so that each read returns the status as of one known edge. It also toggles a bit away and back within the delay, and confirms that the status never moves.

// File: rtl/ckstop_pkg.sv
package ckstop_pkg;

  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2
  } sel_e;

  typedef struct packed {
    sel_e       kind;
    logic [7:0] idx;
  } hit_t;

  // Map a word address to a register class and a word index.
  function automatic hit_t decode_addr(input logic [31:0] a,
                                       input int unsigned cbase,
                                       input int unsigned sbase,
                                       input int unsigned nwords);
    hit_t h;
    h.kind = SEL_NONE;
    h.idx  = '0;
    if (a >= cbase && a < cbase + nwords) begin
      h.kind = SEL_CTRL;
      h.idx  = 8'(a - cbase);
    end else if (a >= sbase && a < sbase + nwords) begin
      h.kind = SEL_STAT;
      h.idx  = 8'(a - sbase);
    end
    return h;
  endfunction

endpackage

// File: rtl/ckstop_regbank.sv
module ckstop_regbank
  import ckstop_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned CTRL_BASE = 'h040,
  parameter int unsigned STAT_BASE = 'h080,
  localparam int unsigned NUM_MOD  = NUM_WORDS * WORD_W
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output logic [NUM_MOD-1:0]  ctrl_q_o,
  output logic [NUM_MOD-1:0]  ctrl_d_o
);

  hit_t wr_hit;
  assign wr_hit = decode_addr(32'(addr_i), CTRL_BASE, STAT_BASE, NUM_WORDS);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic              sel;
    logic [WORD_W-1:0] word_q;

    assign sel = wr_i && (wr_hit.kind == SEL_CTRL) && (wr_hit.idx == 8'(w));
    assign ctrl_d_o[w*WORD_W +: WORD_W] = sel ? wdata_i : word_q;

    always_ff @(posedge clk_i) begin
      if (rst_i) word_q <= '1;
      else       word_q <= ctrl_d_o[w*WORD_W +: WORD_W];
    end

    assign ctrl_q_o[w*WORD_W +: WORD_W] = word_q;
  end

  AST_RESET_ALL_STOPPED: assert property (@(posedge clk_i)
    $past(rst_i) |-> (&ctrl_q_o)) else $error("control not all ones after reset"); // R1

  AST_STRAY_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_i && wr_hit.kind != SEL_CTRL) |=> $stable(ctrl_q_o)) else $error("stray write altered control"); // R8

endmodule

// File: rtl/ckstop_settle.sv
module ckstop_settle #(
  parameter int unsigned NUM_MOD = 128,
  parameter int unsigned SETTLE  = 5,
  localparam int unsigned CNT_W  = (SETTLE > 1) ? $clog2(SETTLE) : 1
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_MOD-1:0] ctrl_q_i,
  input  logic [NUM_MOD-1:0] ctrl_d_i,
  output logic [NUM_MOD-1:0] stat_o
);

  for (genvar i = 0; i < NUM_MOD; i++) begin : g_bit
    logic [CNT_W-1:0] cnt_q;
    logic             st_q;

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        cnt_q <= '0;
        st_q  <= 1'b1;
      end else if (ctrl_d_i[i] != ctrl_q_i[i]) begin
        cnt_q <= '0;
      end else if (ctrl_q_i[i] != st_q) begin
        if (cnt_q == CNT_W'(SETTLE - 1)) begin
          st_q  <= ctrl_q_i[i];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end

    assign stat_o[i] = st_q;
  end

  // Also covers R5: a status bit may only move towards the control value.
  AST_STAT_TAKES_CTRL: assert property (@(posedge clk_i) disable iff (rst_i)
    (((stat_o ^ $past(stat_o)) & (stat_o ^ $past(ctrl_q_i))) == '0)) else $error("status moved away from control"); // R4

  if (SETTLE >= 2) begin : g_quiet_chk
    AST_STAT_NEEDS_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
      (((stat_o ^ $past(stat_o)) & ($past(ctrl_q_i) ^ $past(ctrl_q_i, 2))) == '0)) else $error("status moved right after a toggle"); // R6
  end

endmodule

// File: rtl/ckstop_gate.sv
module ckstop_gate #(
  parameter int unsigned NUM_MOD = 128
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_MOD-1:0] ctrl_q_i,
  output logic [NUM_MOD-1:0] en_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) en_o <= '0;
    else       en_o <= ~ctrl_q_i;
  end

endmodule

// File: rtl/ckstop_rdmux.sv
module ckstop_rdmux
  import ckstop_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned CTRL_BASE = 'h040,
  parameter int unsigned STAT_BASE = 'h080,
  localparam int unsigned NUM_MOD  = NUM_WORDS * WORD_W
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               rd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_MOD-1:0] ctrl_q_i,
  input  logic [NUM_MOD-1:0] stat_i,
  output logic [WORD_W-1:0]  rdata_o
);

  hit_t              rd_hit;
  logic [WORD_W-1:0] rd_word;

  assign rd_hit = decode_addr(32'(addr_i), CTRL_BASE, STAT_BASE, NUM_WORDS);

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < int'(NUM_WORDS); w++) begin
      if (rd_hit.idx == 8'(w)) begin
        if (rd_hit.kind == SEL_CTRL) rd_word = ctrl_q_i[w*WORD_W +: WORD_W];
        if (rd_hit.kind == SEL_STAT) rd_word = stat_i[w*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)     rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_word;
    else           rdata_o <= '0;
  end

  AST_IDLE_READ_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rd_i) |-> (rdata_o == '0)) else $error("read data not zero while idle"); // R9

  AST_HOLE_READ_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(rd_i) && $past(rd_hit.kind) == SEL_NONE) |-> (rdata_o == '0)) else $error("unmapped read returned data"); // R8

endmodule

// File: rtl/ckstop_ctrl.sv
module ckstop_ctrl
  import ckstop_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned CTRL_BASE = 'h040,
  parameter int unsigned STAT_BASE = 'h080,
  parameter int unsigned SETTLE    = 5,
  localparam int unsigned NUM_MOD  = NUM_WORDS * WORD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_MOD-1:0] mod_clk_en
);

  logic [NUM_MOD-1:0] ctrl_q;
  logic [NUM_MOD-1:0] ctrl_d;
  logic [NUM_MOD-1:0] stat;

  ckstop_regbank #(
    .NUM_WORDS (NUM_WORDS),
    .ADDR_W    (ADDR_W),
    .CTRL_BASE (CTRL_BASE),
    .STAT_BASE (STAT_BASE)
  ) u_regbank (
    .clk_i    (clk),
    .rst_i    (rst),
    .wr_i     (bus_wr),
    .addr_i   (bus_addr),
    .wdata_i  (bus_wdata),
    .ctrl_q_o (ctrl_q),
    .ctrl_d_o (ctrl_d)
  );

  ckstop_settle #(
    .NUM_MOD (NUM_MOD),
    .SETTLE  (SETTLE)
  ) u_settle (
    .clk_i    (clk),
    .rst_i    (rst),
    .ctrl_q_i (ctrl_q),
    .ctrl_d_i (ctrl_d),
    .stat_o   (stat)
  );

  ckstop_gate #(
    .NUM_MOD (NUM_MOD)
  ) u_gate (
    .clk_i    (clk),
    .rst_i    (rst),
    .ctrl_q_i (ctrl_q),
    .en_o     (mod_clk_en)
  );

  ckstop_rdmux #(
    .NUM_WORDS (NUM_WORDS),
    .ADDR_W    (ADDR_W),
    .CTRL_BASE (CTRL_BASE),
    .STAT_BASE (STAT_BASE)
  ) u_rdmux (
    .clk_i    (clk),
    .rst_i    (rst),
    .rd_i     (bus_rd),
    .addr_i   (bus_addr),
    .ctrl_q_i (ctrl_q),
    .stat_i   (stat),
    .rdata_o  (bus_rdata)
  );

  AST_STOPPED_NO_EN: assert property (@(posedge clk) disable iff (rst)
    ((mod_clk_en & ctrl_q & $past(ctrl_q)) == '0)) else $error("enable high on a stopped module"); // R3

endmodule

// File: tb/ckstop_ctrl_tb.sv
`timescale 1ns/1ps
module ckstop_ctrl_tb;

  localparam int unsigned NW = 4;
  localparam int unsigned AW = 10;
  localparam int unsigned CB = 'h040;
  localparam int unsigned SB = 'h080;
  localparam int unsigned S  = 5;
  localparam int unsigned NM = NW * 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NM-1:0] mod_clk_en;

  int total = 0;
  int bad   = 0;
  logic [31:0] model [NW];

  always #10 clk = ~clk;

  ckstop_ctrl #(
    .NUM_WORDS (NW), .ADDR_W (AW), .CTRL_BASE (CB), .STAT_BASE (SB), .SETTLE (S)
  ) u_dut (
    .clk (clk), .rst (rst), .bus_wr (bus_wr), .bus_rd (bus_rd),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .mod_clk_en (mod_clk_en)
  );

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_word(input int unsigned a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
    if (a >= CB && a < CB + NW) model[a - CB] = d;
  endtask

  task automatic rd_word(input int unsigned a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all_en(input string req);
    for (int w = 0; w < int'(NW); w++)
      check32(req, mod_clk_en[w*32 +: 32], ~model[w]);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check32("R1 enables", mod_clk_en[31:0] | mod_clk_en[NM-1:NM-32], 32'h0);
    check32("R1 rdata", bus_rdata, 32'h0);
    for (int w = 0; w < int'(NW); w++) begin
      rd_word(CB + w, d); check32("R1 ctrl", d, 32'hFFFF_FFFF);
      rd_word(SB + w, d); check32("R1 stat", d, 32'hFFFF_FFFF);
    end
    idle(1);
    check32("R9 idle zero", bus_rdata, 32'h0);
  endtask

  task automatic t_map;
    logic [31:0] d;
    wr_word(CB + 37 / 32, ~(32'h1 << (37 % 32)));
    idle(1);
    check32("R2 module37 en", {31'h0, mod_clk_en[37]}, 32'h1);
    check_all_en("R2 only module37");
    rd_word(CB + 1, d);
    check32("R2 readback", d, ~(32'h1 << 5));
    wr_word(CB + 2, 32'hA5A5_5A5A);
    rd_word(CB + 2, d);
    check32("R2 pattern", d, 32'hA5A5_5A5A);
    wr_word(CB + 2, 32'hFFFF_FFFF);
    idle(S + 2);
  endtask

  task automatic t_gate;
    wr_word(CB + 2, 32'h0F0F_FFFF);
    check32("R3 lag", mod_clk_en[64 +: 32], 32'h0);
    idle(1);
    check32("R3 enable", mod_clk_en[64 +: 32], 32'hF0F0_0000);
    wr_word(CB + 2, 32'hFFFF_FFFF);
    idle(1);
    check32("R3 stop", mod_clk_en[64 +: 32], 32'h0);
    idle(S + 2);
  endtask

  task automatic t_start;
    logic [31:0] d;
    wr_word(CB + 0, 32'hFFFF_FFF0);
    for (int j = 1; j <= int'(S) + 1; j++) begin
      rd_word(SB + 0, d);
      check32("R4 start settle", d, (j <= int'(S)) ? 32'hFFFF_FFFF : 32'hFFFF_FFF0);
    end
  endtask

  task automatic t_stop;
    logic [31:0] d;
    wr_word(CB + 0, 32'hFFFF_FFFF);
    for (int j = 1; j <= int'(S) + 1; j++) begin
      rd_word(SB + 0, d);
      if (j == 1) check32("R5 enable drops", mod_clk_en[31:0], 32'h0);
      check32("R5 stop settle", d, (j <= int'(S)) ? 32'hFFFF_FFF0 : 32'hFFFF_FFFF);
    end
  endtask

  task automatic t_restart;
    logic [31:0] d;
    wr_word(CB + 3, 32'hFFFF_FFFE);
    idle(2);
    wr_word(CB + 3, 32'hFFFF_FFFF);
    idle(2);
    wr_word(CB + 3, 32'hFFFF_FFFE);
    for (int j = 1; j <= int'(S) + 1; j++) begin
      rd_word(SB + 3, d);
      check32("R6 restart", d, (j <= int'(S)) ? 32'hFFFF_FFFF : 32'hFFFF_FFFE);
    end
    wr_word(CB + 3, 32'hFFFF_FFFC);
    idle(2);
    wr_word(CB + 3, 32'hFFFF_FFFE);
    idle(S + 3);
    rd_word(SB + 3, d);
    check32("R6 cancel", d, 32'hFFFF_FFFE);
  endtask

  task automatic t_stat_write;
    logic [31:0] d;
    wr_word(SB + 3, 32'h0);
    idle(S + 2);
    rd_word(SB + 3, d); check32("R7 stat kept", d, 32'hFFFF_FFFE);
    rd_word(CB + 3, d); check32("R7 ctrl kept", d, 32'hFFFF_FFFE);
    check_all_en("R7 enables kept");
  endtask

  task automatic t_undef;
    logic [31:0] d;
    wr_word(CB + NW, 32'h0);
    wr_word(0, 32'h0);
    wr_word(SB + NW, 32'h0);
    wr_word(2**AW - 1, 32'h0);
    idle(2);
    check_all_en("R8 enables kept");
    for (int w = 0; w < int'(NW); w++) begin
      rd_word(CB + w, d); check32("R8 ctrl kept", d, model[w]);
    end
    rd_word(CB + NW, d);     check32("R8 read hole", d, 32'h0);
    rd_word(0, d);           check32("R8 read zero addr", d, 32'h0);
    rd_word(2**AW - 1, d);   check32("R8 read top addr", d, 32'h0);
    idle(1);
    check32("R9 idle after read", bus_rdata, 32'h0);
  endtask

  initial begin
    for (int w = 0; w < int'(NW); w++) model[w] = 32'hFFFF_FFFF;
    idle(5);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_map();
    t_gate();
    t_start();
    t_stop();
    t_restart();
    t_stat_write();
    t_undef();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule